// File: doc/BRIEF.md
# Gated 13-bit Counter/Timer

This block keeps a 13-bit count, stored as a 5-bit low field that carries into an 8-bit high field. Each advance of the count comes from one of three sources. The first is a falling edge on an external count pin. The second is every system clock cycle. The third is a tick from a prescaler that sits outside the block and arrives as a one-cycle enable. When the count wraps from its maximum back to zero, it raises a sticky overflow flag.

Counting is allowed only while a run bit is set. Optionally, a hardware gate can also hold the counter back. The gate is an external line whose active level is programmable. Keeping the gate enabled and letting the line's active phase open the counter gives a direct measure of pulse width in count ticks.

Software loads the two count fields through plain write strobes that share one data bus. It reads both fields and the control byte back at all times. The block has no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `gated_count13`

## Requirements
- R1: A synchronous active-high `rst` clears the count, the overflow flag and all control bits, so `lo_rd`, `hi_rd` and `ctl_rd` read 0.
- R2: When the low field holds 31 and the count advances, the low field becomes 0 and the high field increments by one.
- R3: With ext_mode (control bit 3) set, each high-to-low transition of `cnt_pin` advances the count once. The pin passes through two synchronizer flops and an edge register, so the change shows on the readback after the third rising clock edge that follows the pin change.
- R4: With ext_mode clear, sys_sel (control bit 4) set advances the count on every clock cycle. With sys_sel clear, the count advances only in cycles where `presc_tick` is 1.
- R5: With run (control bit 0) at 0, the count never advances, whatever the gate.
- R6: With gate_en (control bit 1) set, the count advances only while the two-flop synchronized `gate_pin` XOR gate_pol (control bit 2) equals 1. With gate_en clear, the gate pin has no effect.
- R7: `wr_lo` loads `wr_data[4:0]` into the low field and `wr_hi` loads `wr_data[7:0]` into the high field. Setting run leaves the loaded count unchanged.
- R8: In any cycle with `wr_lo` or `wr_hi`, the count does not advance; the write alone decides the new value.
- R9: An advance from 0x1FFF gives a count of 0 and sets `ovf_flag` (also `ctl_rd[5]`), which then holds at 1.
- R10: `ovf_flag` is cleared by an `ovf_ack` pulse or by a `wr_ctl` with `wr_data[5]` = 0. A new overflow in the same cycle wins over the clear.
- R11: `lo_rd[7:5]` always read 0, and `ctl_rd` reads {2'b00, ovf, sys_sel, ext_mode, gate_pol, gate_en, run}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Load low count field from wr_data[4:0] |
| wr_hi | input | 1 | Load high count field from wr_data |
| wr_ctl | input | 1 | Load control bits from wr_data[4:0]; wr_data[5]=0 clears overflow |
| wr_data | input | 8 | Write data shared by all write strobes |
| presc_tick | input | 1 | One-cycle enable from the external prescaler |
| cnt_pin | input | 1 | Asynchronous external count input, falling edges counted |
| gate_pin | input | 1 | Asynchronous external gate line |
| ovf_ack | input | 1 | Pulse that clears the overflow flag |
| lo_rd | output | 8 | Low field readback, upper 3 bits zero |
| hi_rd | output | 8 | High field readback |
| ctl_rd | output | 8 | Control and overflow readback |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The whole state of the block shows on `lo_rd`, `hi_rd` and `ctl_rd`, so a wrong count, lost carry, missed edge or stuck flag appears on these ports at the very next falling clock edge after the faulty update. The only exceptions are the synchronizer and edge registers. A fault in those shows up as a count that is early, late or missing, at most three cycles after the pin change that should have caused it. The bench compares every readback on every cycle against a cycle-level model, so a divergence is caught in the cycle it first appears.

// File: rtl/tmr13_pkg.sv
package tmr13_pkg;
  localparam int DATA_W = 8;
  localparam int CTL_W  = 5;
  localparam int OVF_WBIT = 5;

  typedef struct packed {
    logic sys_sel;   // bit 4
    logic ext_mode;  // bit 3
    logic gate_pol;  // bit 2
    logic gate_en;   // bit 1
    logic run;       // bit 0
  } tmr_ctl_t;
endpackage

// File: rtl/tmr13_sync.sv
module tmr13_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        if (i == 0) sr[i] <= d;
        else        sr[i] <= sr[i-1];
      end
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/tmr13_source.sv
module tmr13_source
  import tmr13_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  tmr_ctl_t ctl,
  input  logic     cnt_s,
  input  logic     gate_s,
  input  logic     presc_tick,
  output logic     adv
);
  logic cnt_prev;
  logic fall;
  logic tick;
  logic gate_open;

  always_ff @(posedge clk) begin
    if (rst) cnt_prev <= 1'b0;
    else     cnt_prev <= cnt_s;
  end

  assign fall      = cnt_prev & ~cnt_s;
  assign gate_open = ~ctl.gate_en | (gate_s ^ ctl.gate_pol);

  always_comb begin
    if (ctl.ext_mode)     tick = fall;
    else if (ctl.sys_sel) tick = 1'b1;
    else                  tick = presc_tick;
  end

  assign adv = ctl.run & gate_open & tick;

  // R5
  run_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.run |-> !adv);

  // R6
  gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.gate_en && (gate_s == ctl.gate_pol)) |-> !adv);
endmodule

// File: rtl/tmr13_counter.sv
module tmr13_counter #(
  parameter int LO_W   = 5,
  parameter int HI_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ovf_clr,
  output logic [LO_W-1:0]   lo,
  output logic [HI_W-1:0]   hi,
  output logic              ovf
);
  localparam logic [LO_W-1:0] LO_MAX = {LO_W{1'b1}};
  localparam logic [HI_W-1:0] HI_MAX = {HI_W{1'b1}};

  logic wr_any;
  logic inc;
  logic lo_wrap;
  logic full_wrap;

  assign wr_any    = wr_lo | wr_hi;
  assign inc       = adv & ~wr_any;
  assign lo_wrap   = (lo == LO_MAX);
  assign full_wrap = inc & lo_wrap & (hi == HI_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else if (wr_any) begin
      if (wr_lo) lo <= wr_data[LO_W-1:0];
      if (wr_hi) hi <= wr_data[HI_W-1:0];
    end else if (inc) begin
      lo <= lo + 1'b1;
      if (lo_wrap) hi <= hi + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ovf <= 1'b0;
    else if (full_wrap) ovf <= 1'b1;
    else if (ovf_clr)   ovf <= 1'b0;
  end

  // R2
  carry_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_lo && !wr_hi && lo == LO_MAX && hi != HI_MAX)
      |=> (lo == '0 && hi == $past(hi) + 1'b1));

  // R8
  wr_lo_prio_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> lo == $past(wr_data[LO_W-1:0]));

  // R9
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_lo && !wr_hi && lo == LO_MAX && hi == HI_MAX)
      |=> (ovf && lo == '0 && hi == '0));

  // R10
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(adv && !wr_lo && !wr_hi && lo == LO_MAX && hi == HI_MAX))
      |=> !ovf);
endmodule

// File: rtl/gated_count13.sv
module gated_count13
  import tmr13_pkg::*;
#(
  parameter int LO_W        = 5,
  parameter int HI_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              presc_tick,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              ovf_ack,
  output logic [DATA_W-1:0] lo_rd,
  output logic [DATA_W-1:0] hi_rd,
  output logic [DATA_W-1:0] ctl_rd,
  output logic              ovf_flag
);
  localparam int LO_PAD  = DATA_W - LO_W;
  localparam int CTL_PAD = DATA_W - CTL_W - 1;

  tmr_ctl_t        ctl;
  logic            cnt_s;
  logic            gate_s;
  logic            adv;
  logic            ovf_clr;
  logic [LO_W-1:0] lo;
  logic [HI_W-1:0] hi;

  always_ff @(posedge clk) begin
    if (rst)         ctl <= '0;
    else if (wr_ctl) ctl <= tmr_ctl_t'(wr_data[CTL_W-1:0]);
  end

  assign ovf_clr = ovf_ack | (wr_ctl & ~wr_data[OVF_WBIT]);

  tmr13_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst(rst), .d(cnt_pin), .q(cnt_s)
  );

  tmr13_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst(rst), .d(gate_pin), .q(gate_s)
  );

  tmr13_source u_src (
    .clk(clk), .rst(rst), .ctl(ctl), .cnt_s(cnt_s), .gate_s(gate_s),
    .presc_tick(presc_tick), .adv(adv)
  );

  tmr13_counter #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .adv(adv), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .ovf_clr(ovf_clr), .lo(lo), .hi(hi), .ovf(ovf_flag)
  );

  assign lo_rd  = {{LO_PAD{1'b0}}, lo};
  assign hi_rd  = hi;
  assign ctl_rd = {{CTL_PAD{1'b0}}, ovf_flag, ctl};

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.run && !wr_lo && !wr_hi) |=> $stable({hi, lo}));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (lo_rd == '0 && hi_rd == '0 && ctl_rd == '0));
endmodule

// File: tb/tb_gated_count13.sv
module tb_gated_count13;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_lo = 0, wr_hi = 0, wr_ctl = 0;
  logic [7:0] wr_data = 0;
  logic       presc_tick = 0, cnt_pin = 1, gate_pin = 0, ovf_ack = 0;
  logic [7:0] lo_rd, hi_rd, ctl_rd;
  logic       ovf_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;  // 125 MHz

  gated_count13 dut (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctl(wr_ctl),
    .wr_data(wr_data), .presc_tick(presc_tick), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ovf_ack(ovf_ack), .lo_rd(lo_rd), .hi_rd(hi_rd),
    .ctl_rd(ctl_rd), .ovf_flag(ovf_flag)
  );

  // Reference model state, built from the requirements
  logic [12:0] m_cnt = 0;
  logic        m_ovf = 0;
  logic [4:0]  m_ctl = 0;  // {sys, ext, pol, gen, run}
  logic        m_c1 = 0, m_c2 = 0, m_cp = 0, m_g1 = 0, m_g2 = 0;

  function automatic logic m_adv(input logic [4:0] c, input logic c2,
                                 input logic cp, input logic g2,
                                 input logic pt);
    logic tick;
    if (c[3])      tick = cp & ~c2;          // R3 falling edge
    else if (c[4]) tick = 1'b1;              // R4 system clock
    else           tick = pt;                // R4 prescaled
    return c[0] & (~c[1] | (g2 ^ c[2])) & tick;  // R5 R6
  endfunction

  always @(posedge clk) begin
    logic a;
    a = m_adv(m_ctl, m_c2, m_cp, m_g2, presc_tick);
    if (rst) begin
      m_cnt = 0; m_ovf = 0; m_ctl = 0;
      m_c1 = 0; m_c2 = 0; m_cp = 0; m_g1 = 0; m_g2 = 0;
    end else begin
      logic wrap;
      wrap = 0;
      if (wr_lo || wr_hi) begin
        if (wr_lo) m_cnt[4:0]  = wr_data[4:0];
        if (wr_hi) m_cnt[12:5] = wr_data;
      end else if (a) begin
        wrap  = (m_cnt == 13'h1FFF);
        m_cnt = m_cnt + 13'd1;
      end
      if (wrap) m_ovf = 1;
      else if (ovf_ack || (wr_ctl && !wr_data[5])) m_ovf = 0;
      if (wr_ctl) m_ctl = wr_data[4:0];
      m_cp = m_c2; m_c2 = m_c1; m_c1 = cnt_pin;
      m_g2 = m_g1; m_g1 = gate_pin;
    end
  end

  task automatic check(input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " lo"},  lo_rd,  {3'b000, m_cnt[4:0]});
    check({tag, " hi"},  hi_rd,  m_cnt[12:5]);
    check({tag, " ctl"}, ctl_rd, {2'b00, m_ovf, m_ctl});
    check({tag, " ovf"}, {7'd0, ovf_flag}, {7'd0, m_ovf});
  endtask

  // one clock, then compare at the falling edge and drop pulses
  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
    wr_lo = 0; wr_hi = 0; wr_ctl = 0; ovf_ack = 0;
  endtask

  task automatic wctl(input logic [7:0] d, input string tag);
    wr_ctl = 1; wr_data = d; step(tag);
  endtask

  task automatic wcnt(input logic [12:0] v, input string tag);
    wr_lo = 1; wr_hi = 1; wr_data = {3'b111, v[4:0]};
    @(posedge clk);
    @(negedge clk);
    wr_lo = 0; wr_data = v[12:5];
    step(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C13));
    repeat (3) @(negedge clk);
    rst = 1;
    step("R1 reset");
    check("R1 reset lo", lo_rd, 8'h00);
    check("R1 reset ctl", ctl_rd, 8'h00);
    rst = 0;

    // R7 R11: load 31 into low (upper data bits ignored), high 0x10
    wcnt({8'h10, 5'h1F}, "R7 load");
    check("R11 lo pad", lo_rd, 8'h1F);
    check("R7 hi load", hi_rd, 8'h10);
    wctl(8'h31, "R7 run set keeps count");   // run, sys_sel, ovf bit 1
    check("R7 count held", lo_rd, 8'h1F);
    step("R2 carry");
    check("R2 carry lo", lo_rd, 8'h00);
    check("R2 carry hi", hi_rd, 8'h11);
    // R8: write while counting
    wr_lo = 1; wr_data = 8'h05; step("R8 write priority");
    check("R8 write wins", lo_rd, 8'h05);

    // R9 overflow
    wctl(8'h30, "R5 stop");
    wcnt(13'h1FFF, "R9 load max");
    step("R5 hold");
    check("R5 held", hi_rd, 8'hFF);
    wctl(8'h31, "R9 run");
    step("R9 wrap");
    check("R9 flag", {7'd0, ovf_flag}, 8'h01);
    check("R9 zero", hi_rd, 8'h00);
    step("R9 sticky");
    // R10 clear by ack, and by control write with bit5=0
    ovf_ack = 1; step("R10 ack");
    check("R10 ack clear", {7'd0, ovf_flag}, 8'h00);
    wctl(8'h30, "R10 stop");
    wcnt(13'h1FFF, "R10 reload");
    wctl(8'h31, "R10 run");
    step("R10 wrap again");
    wctl(8'h10, "R10 ctl clear");
    check("R10 ctl clear", ctl_rd, 8'h10);
    // set wins over ack
    wcnt(13'h1FFF, "R10 load");
    wctl(8'h31, "R10 run");
    ovf_ack = 1; step("R10 set wins");
    check("R10 set wins", {7'd0, ovf_flag}, 8'h01);

    // R3 external falling edges
    wctl(8'h09, "R3 ext mode");
    wcnt(13'h0000, "R3 clear");
    for (int i = 0; i < 6; i++) begin
      cnt_pin = ~cnt_pin;
      repeat (4) step("R3 edge");
    end
    check("R3 three falls", lo_rd, 8'h03);

    // R6 gate, polarity 0 and 1
    wctl(8'h13, "R6 gate pol0");
    wcnt(13'h0000, "R6 clear");
    gate_pin = 0;
    repeat (5) step("R6 closed");
    check("R6 closed", lo_rd, 8'h00);
    gate_pin = 1;
    repeat (5) step("R6 open");
    wctl(8'h17, "R6 gate pol1");
    repeat (5) step("R6 pol1 closed");
    // R4 prescaled tick
    wctl(8'h01, "R4 presc");
    wcnt(13'h0000, "R4 clear");
    for (int i = 0; i < 10; i++) begin
      presc_tick = i[0];
      step("R4 tick");
    end
    presc_tick = 0;
    step("R4 tick end");
    check("R4 five ticks", lo_rd, 8'h05);

    // constrained random phase: R2 R3 R4 R5 R6 R8 R9 R10
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom_range(0, 999);
      wr_data = 8'($urandom);
      if (r < 15) begin
        wr_lo = 1;
      end else if (r < 30) begin
        wr_hi = 1;
        if ($urandom_range(0, 1) == 1) wr_data = 8'hFF;
      end else if (r < 45) begin
        wr_ctl = 1;
        if ($urandom_range(0, 9) < 8) wr_data[0] = 1'b1;
      end else if (r < 55) begin
        ovf_ack = 1;
      end
      presc_tick = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 4) == 0) cnt_pin = ~cnt_pin;
      if ($urandom_range(0, 9) == 0) gate_pin = ~gate_pin;
      step("R2 R4 R6 R9 random");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule